// File: doc/BRIEF.md
# Power-On Reset Conditioner

This block cleans up a raw power-on reset before it reaches the rest of the chip. The input is active low, arrives with no timing relation to the clock, and may carry noise spikes. The block gives back an active-low reset whose release always lines up with a rising clock edge. A build-time parameter chooses between two ways of doing this.

In filtering mode the raw input is sampled into a register chain, and the output is the OR of the newest sample and a sample `TAP_GAP` positions older. A low pulse therefore has to last longer than `TAP_GAP` samples before the output falls. Because the two OR inputs are never neighbours in the chain, a short pulse cannot make the OR change twice. In hold mode every flop in a `STAGES`-long chain is cleared directly by the low input, so the output falls at once even with no clock running. The output then comes back high only after `STAGES` clean edges, which gives a metastable first stage time to settle.

Top module: `por_conditioner`

## Requirements
- R1: Every chain flop starts at 0. In both modes the output is therefore low (asserted) before the first rising clock edge, even when the input is high.
- R2: Filtering mode: the output goes low right after the rising edge that takes the (`TAP_GAP`+1)-th consecutive low sample of the input. It stays low while later samples are low.
- R3: Filtering mode: if the input is low for `TAP_GAP` or fewer consecutive samples, and the `TAP_GAP` samples before that pulse were high, the output stays high.
- R4: Filtering mode: the output is high right after any rising edge that samples the input high. Release therefore comes on the first high sample.
- R5: Filtering mode: the output changes only at rising clock edges. A change of the input that is not present at an edge, or that happens while the clock is stopped, never reaches the output.
- R6: Hold mode: whenever the input is low, the output is low. This does not depend on any clock edge, and it holds while the clock is stopped.
- R7: Hold mode: once the input returns high, the output rises at exactly the `STAGES`-th rising edge that samples it high. Any low on the input before that point restarts the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| por_raw_n | input | 1 | Raw power-on reset, active low, asynchronous to `clk` |
| rst_out_n | output | 1 | Conditioned reset, active low, released on a rising edge |

## Verification
In filtering mode the output is due right after the edge that takes the deciding sample. Release follows one edge after a high input, and assertion follows the (`TAP_GAP`+1)-th low. The bench therefore changes the input on the falling edge and reads the output 2 ns after the next rising edge. In hold mode the bench reads the output in the middle of a low pulse, with the clock either running or gated off, to check that the output falls at once. It then counts edges after release and expects the rise at exactly the `STAGES`-th edge. A monitor flags any output change in filtering mode that does not fall on a rising-edge instant.

// File: rtl/por_conditioner.sv
module por_conditioner #(
  parameter bit          ASYNC_ASSERT = 1'b0,
  parameter int unsigned TAP_GAP      = 2,
  parameter int unsigned STAGES       = 3
) (
  input  logic clk,
  input  logic por_raw_n,
  output logic rst_out_n
);

  generate
    if (!ASYNC_ASSERT) begin : g_filt
      logic [TAP_GAP:0] tap = '0;

      always_ff @(posedge clk)
        tap <= {tap[TAP_GAP-1:0], por_raw_n};

      // newest sample OR'd with a non-adjacent older one
      assign rst_out_n = tap[0] | tap[TAP_GAP];
    end else begin : g_hold
      logic [STAGES-1:0] chain = '0;

      always_ff @(posedge clk or negedge por_raw_n)
        if (!por_raw_n) chain <= '0;
        else            chain <= {chain[STAGES-2:0], 1'b1};

      assign rst_out_n = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/por_conditioner_chk.sv
module por_conditioner_chk #(
  parameter bit          ASYNC_ASSERT = 1'b0,
  parameter int unsigned TAP_GAP      = 2,
  parameter int unsigned STAGES       = 3
) (
  input logic clk,
  input logic por_raw_n,
  input logic rst_out_n
);

  localparam int W = $clog2(STAGES + TAP_GAP + 2);

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  generate
    if (!ASYNC_ASSERT) begin : g_s
      logic [W-1:0] lo_run = '0;

      always_ff @(posedge clk)
        if (por_raw_n)                lo_run <= '0;
        else if (lo_run <= W'(TAP_GAP)) lo_run <= lo_run + 1'b1;

      p_release_r4: assert property (@(posedge clk) disable iff (!armed)
        $past(por_raw_n) |-> rst_out_n);

      p_long_low_r2: assert property (@(posedge clk) disable iff (!armed)
        (lo_run > W'(TAP_GAP)) |-> !rst_out_n);
    end else begin : g_a
      logic [W-1:0] hi_run = '0;

      always_ff @(posedge clk or negedge por_raw_n)
        if (!por_raw_n)                hi_run <= '0;
        else if (hi_run != W'(STAGES)) hi_run <= hi_run + 1'b1;

      p_hold_low_r6: assert property (@(posedge clk) disable iff (!armed)
        !por_raw_n |-> !rst_out_n);

      p_edge_count_r7: assert property (@(posedge clk) disable iff (!armed)
        rst_out_n == (hi_run == W'(STAGES)));
    end
  endgenerate

endmodule

bind por_conditioner por_conditioner_chk #(
  .ASYNC_ASSERT(ASYNC_ASSERT),
  .TAP_GAP(TAP_GAP),
  .STAGES(STAGES)
) u_chk (
  .clk(clk),
  .por_raw_n(por_raw_n),
  .rst_out_n(rst_out_n)
);

// File: tb/sim_por_conditioner.sv
module sim_por_conditioner;

  localparam int PERIOD = 10;
  localparam int HALF   = PERIOD / 2;
  localparam int NVEC   = 20;

  // each entry: {raw input, expected filtering out (gap 2), expected hold out (3 stages)}
  localparam logic [2:0] VEC [NVEC] = '{
    3'b111, 3'b010, 3'b110, 3'b110, 3'b010,
    3'b010, 3'b110, 3'b110, 3'b010, 3'b010,
    3'b000, 3'b000, 3'b110, 3'b110, 3'b010,
    3'b110, 3'b110, 3'b111, 3'b111, 3'b111
  };

  logic free_clk = 1'b0;
  logic clk_en   = 1'b1;
  logic clk;
  logic raw0 = 1'b1;
  logic raw2 = 1'b1;
  logic out_s, out_a, out_w;

  int checks = 0;
  int fails  = 0;
  int glitches = 0;
  bit done = 1'b0;

  assign clk = free_clk & clk_en;
  always #(HALF) free_clk = ~free_clk;

  por_conditioner #(.ASYNC_ASSERT(1'b0), .TAP_GAP(2), .STAGES(3))
    u0 (.clk(clk), .por_raw_n(raw0), .rst_out_n(out_s));
  por_conditioner #(.ASYNC_ASSERT(1'b1), .TAP_GAP(2), .STAGES(3))
    u1 (.clk(clk), .por_raw_n(raw0), .rst_out_n(out_a));
  por_conditioner #(.ASYNC_ASSERT(1'b0), .TAP_GAP(4), .STAGES(3))
    u2 (.clk(clk), .por_raw_n(raw2), .rst_out_n(out_w));

  // R5: filtering outputs may move only at a rising-edge instant
  always @(out_s or out_w)
    if ($time != 0 && ($time % PERIOD) != HALF) glitches++;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic edge_then_sample;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #1;
    chk("R1 filter out at power-up", out_s, 1'b0);
    chk("R1 hold out at power-up",   out_a, 1'b0);
    chk("R1 wide filter at power-up", out_w, 1'b0);

    edge_then_sample;
    chk("R4 filter releases on first high sample", out_s, 1'b1);
    chk("R7 hold low after edge 1", out_a, 1'b0);
    edge_then_sample;
    chk("R7 hold low after edge 2", out_a, 1'b0);
    edge_then_sample;
    chk("R7 hold high after edge 3", out_a, 1'b1);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      raw0 = VEC[i][2];
      edge_then_sample;
      chk($sformatf("R2/R3/R4 filter vector %0d", i), out_s, VEC[i][1]);
      chk($sformatf("R6/R7 hold vector %0d", i),      out_a, VEC[i][0]);
    end

    // narrow spike between edges
    #1 raw0 = 1'b0;
    #1;
    chk("R6 hold drops on mid-cycle spike", out_a, 1'b0);
    chk("R5 filter ignores mid-cycle spike", out_s, 1'b1);
    #1 raw0 = 1'b1;
    edge_then_sample;
    chk("R7 hold low after spike edge 1", out_a, 1'b0);
    chk("R5 filter high after spike", out_s, 1'b1);
    edge_then_sample;
    chk("R7 hold low after spike edge 2", out_a, 1'b0);
    edge_then_sample;
    chk("R7 hold high after spike edge 3", out_a, 1'b1);

    // clock stopped
    @(negedge free_clk);
    clk_en = 1'b0;
    #2 raw0 = 1'b0;
    #2;
    chk("R6 hold drops with clock stopped", out_a, 1'b0);
    #(PERIOD * 3);
    chk("R6 hold stays low with clock stopped", out_a, 1'b0);
    chk("R5 filter unchanged with clock stopped", out_s, 1'b1);
    raw0 = 1'b1;
    @(negedge free_clk);
    clk_en = 1'b1;
    edge_then_sample;
    chk("R7 hold low at restart edge 1", out_a, 1'b0);
    edge_then_sample;
    chk("R7 hold low at restart edge 2", out_a, 1'b0);
    edge_then_sample;
    chk("R7 hold high at restart edge 3", out_a, 1'b1);

    // wider gap: 4-sample low is rejected
    @(negedge clk);
    raw2 = 1'b0;
    for (int k = 0; k < 4; k++) begin
      edge_then_sample;
      chk($sformatf("R3 gap-4 filter holds high, low sample %0d", k + 1), out_w, 1'b1);
      if (k < 3) @(negedge clk);
    end
    @(negedge clk);
    raw2 = 1'b1;
    for (int k = 0; k < 5; k++) begin
      edge_then_sample;
      chk("R4 gap-4 filter high between pulses", out_w, 1'b1);
    end

    // 5-sample low asserts on the fifth
    @(negedge clk);
    raw2 = 1'b0;
    for (int k = 0; k < 5; k++) begin
      edge_then_sample;
      chk($sformatf("R2 gap-4 filter low sample %0d", k + 1), out_w, (k == 4) ? 1'b0 : 1'b1);
    end
    @(negedge clk);
    edge_then_sample;
    chk("R2 gap-4 filter stays low", out_w, 1'b0);
    @(negedge clk);
    raw2 = 1'b1;
    edge_then_sample;
    chk("R4 gap-4 filter releases on first high", out_w, 1'b1);

    checks++;
    if (glitches != 0) begin
      fails++;
      $display("FAIL R5 off-edge output changes: actual %0d expected 0", glitches);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 5000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule